// File: doc/BRIEF.md
# Three-Mode Time Delay Unit

This block is a timer cell for interlock and sequencing logic. It watches one synchronous logic input and drives one logic output. A static mode input picks one of three behaviours: delayed turn-on, delayed turn-off, or a fixed-width pulse that cannot be retriggered. The time is a programmable count of tick-enable pulses. The ticks come from a prescaler outside the block, so the same cell can time in microseconds or in minutes.

All three modes share one up-counter. Every output of the block is a register. Each response therefore appears on the clock edge that samples the condition causing it. A busy flag reports that the counter is running toward an output transition.

Top module: `tdu_timer`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `dout_o` and `busy_o` are low.
- R2: Mode encoding on `mode_i`: 0 is on-delay, 1 is off-delay, 2 is pulse, and 3 behaves as on-delay. The mode changes only while reset is held.
- R3: On-delay: with `din_i` held high, `dout_o` rises on the edge that samples the P-th tick counted while the input is high, where P is `period_i`.
- R4: On-delay: a low `din_i` drives `dout_o` low on the next edge and clears the count. An input high for fewer than P ticks produces no output at all.
- R5: Off-delay: a high `din_i` drives `dout_o` high on the next edge.
- R6: Off-delay: after `din_i` falls, `dout_o` stays high until P ticks have been sampled with the input low, and it falls on the edge of the P-th tick. If the input rises again first, the countdown is cancelled and the output stays high.
- R7: Pulse: a rising input (high now, low on the previous sampled cycle) while `dout_o` is low makes `dout_o` high on the next edge. The output then stays high for exactly P ticks, whatever the input does.
- R8: Pulse: input edges during an active pulse are ignored. A new pulse needs a rising input sampled while the output is low.
- R9: A period of zero makes modes 0, 1 and 3 follow the input with one cycle of latency, and makes mode 2 emit no pulse.
- R10: `busy_o` is high after an edge exactly when the counter is running: on-delay with the input high and the output low, off-delay with the input low and the output high, or pulse with the output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Timer behaviour select, held static |
| tick_i | input | 1 | Time-base enable pulse from the prescaler |
| din_i | input | 1 | Logic input being timed |
| period_i | input | CNT_W | Delay or pulse length in ticks |
| dout_o | output | 1 | Timed logic output |
| busy_o | output | 1 | Counter running toward a transition |

## Verification
Every result of this block comes from a register. A change in `dout_o` or `busy_o` is therefore due on the first rising edge that samples the input, tick and period values causing it, and never later. The bench drives its inputs on the falling edge. It advances its reference model on the rising edge from those same input values, and it compares both outputs on the following falling edge. Each comparison therefore sees exactly the edge the requirement names. The stimulus covers all four mode codes at zero and non-zero periods, with ticks on every cycle and on every third cycle, and with input changes placed just short of, at, and past the programmed period.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
  typedef enum logic [1:0] {
    TM_ON_DELAY  = 2'd0,
    TM_OFF_DELAY = 2'd1,
    TM_PULSE     = 2'd2,
    TM_ON_ALT    = 2'd3
  } tmode_e;

  function automatic logic is_on_mode(input logic [1:0] m);
    return (m == TM_ON_DELAY) || (m == TM_ON_ALT);
  endfunction
endpackage

// File: rtl/tdu_counter.sv
module tdu_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] period,
  output logic             hit,
  output logic             per_zero
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [EXT_W-1:0] cnt_nx;

  assign cnt_nx   = {1'b0, cnt} + EXT_W'(1);
  assign hit      = cnt_nx >= {1'b0, period};
  assign per_zero = (period == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt_nx[CNT_W-1:0];
  end

  // R6: the count never advances past the terminal value while it is in use
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    inc |-> !hit);
endmodule

// File: rtl/tdu_ctrl.sv
module tdu_ctrl
  import tdu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       din,
  input  logic       tick,
  input  logic       hit,
  input  logic       per_zero,
  output logic       clr,
  output logic       inc,
  output logic       out_q,
  output logic       busy_q
);
  logic in_d;
  logic out_n, busy_n;

  always_comb begin
    out_n = out_q;
    clr   = 1'b1;
    inc   = 1'b0;
    case (mode)
      TM_OFF_DELAY: begin
        if (din) out_n = 1'b1;
        else if (out_q) begin
          if (per_zero) out_n = 1'b0;
          else if (tick) begin
            if (hit) out_n = 1'b0;
            else begin clr = 1'b0; inc = 1'b1; end
          end else clr = 1'b0;
        end
        busy_n = !din && out_n;
      end
      TM_PULSE: begin
        if (out_q) begin
          if (tick) begin
            if (hit) out_n = 1'b0;
            else begin clr = 1'b0; inc = 1'b1; end
          end else clr = 1'b0;
        end else if (din && !in_d && !per_zero) out_n = 1'b1;
        busy_n = out_n;
      end
      default: begin
        if (!din) out_n = 1'b0;
        else if (!out_q) begin
          if (per_zero) out_n = 1'b1;
          else if (tick) begin
            if (hit) out_n = 1'b1;
            else begin clr = 1'b0; inc = 1'b1; end
          end else clr = 1'b0;
        end
        busy_n = din && !out_n;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      busy_q <= 1'b0;
      in_d   <= 1'b0;
    end else begin
      out_q  <= out_n;
      busy_q <= busy_n;
      in_d   <= din;
    end
  end

  // R4: a low input in on-delay clears the output on the next edge
  p_on_drop_r4: assert property (@(posedge clk) disable iff (rst)
    is_on_mode(mode) && !din |=> !out_q);
  // R5: off-delay output follows a high input on the next edge
  p_off_raise_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == TM_OFF_DELAY) && din |=> out_q);
  // R8: an active pulse holds through cycles without a tick
  p_pulse_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == TM_PULSE) && out_q && !tick |=> out_q);
  // R9: a zero period never starts a pulse
  p_zero_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == TM_PULSE) && per_zero && !out_q |=> !out_q);
  // R10: on-delay busy and output are never high together
  p_busy_on_r10: assert property (@(posedge clk) disable iff (rst)
    is_on_mode(mode) |-> !(busy_q && out_q));
endmodule

// File: rtl/tdu_timer.sv
module tdu_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             tick_i,
  input  logic             din_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             dout_o,
  output logic             busy_o
);
  logic clr, inc, hit, per_zero;

  tdu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .inc(inc),
    .period(period_i), .hit(hit), .per_zero(per_zero)
  );

  tdu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode(mode_i), .din(din_i), .tick(tick_i),
    .hit(hit), .per_zero(per_zero), .clr(clr), .inc(inc),
    .out_q(dout_o), .busy_q(busy_o)
  );

  // R1: the cycle after reset starts from an idle, low output
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> !dout_o && !busy_o);
endmodule

// File: tb/tdu_timer_tb.sv
module tdu_timer_tb;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       mode_i = 2'd0;
  logic             tick_i = 1'b0;
  logic             din_i = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic             dout_o, busy_o;

  int applied = 0, miscompares = 0;
  int tick_div = 1, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_out = 0, m_busy = 0, m_cnt = 0, m_prev = 0;

  tdu_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .tick_i(tick_i), .din_i(din_i),
    .period_i(period_i), .dout_o(dout_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  // Reference model: timer behaviour in elapsed ticks
  always @(posedge clk) begin
    int per, i;
    per = int'(period_i);
    i = int'(din_i);
    if (rst) begin
      m_out = 0; m_busy = 0; m_cnt = 0; m_prev = 0;
    end else begin
      if (mode_i == 2'd1) begin
        if (i == 1) begin m_out = 1; m_cnt = 0; end
        else if (m_out == 1) begin
          if (per == 0) m_out = 0;
          else if (tick_i) begin
            m_cnt++;
            if (m_cnt >= per) begin m_out = 0; m_cnt = 0; end
          end
        end
        m_busy = (i == 0 && m_out == 1) ? 1 : 0;
      end else if (mode_i == 2'd2) begin
        if (m_out == 1) begin
          if (tick_i) begin
            m_cnt++;
            if (m_cnt >= per) begin m_out = 0; m_cnt = 0; end
          end
        end else if (i == 1 && m_prev == 0 && per != 0) begin
          m_out = 1; m_cnt = 0;
        end
        m_busy = m_out;
      end else begin
        if (i == 0) begin m_out = 0; m_cnt = 0; end
        else if (m_out == 0) begin
          if (per == 0) m_out = 1;
          else if (tick_i) begin
            m_cnt++;
            if (m_cnt >= per) begin m_out = 1; m_cnt = 0; end
          end
        end
        m_busy = (i == 1 && m_out == 0) ? 1 : 0;
      end
      m_prev = i;
    end
  end

  // Compare and drive ticks on the falling edge
  always @(negedge clk) begin
    if (!done) begin
      applied++;
      if (int'(dout_o) != m_out) begin
        miscompares++;
        $display("FAIL %s dout_o actual=%0d expected=%0d t=%0t", cur_req, dout_o, m_out, $time);
      end
      applied++;
      if (int'(busy_o) != m_busy) begin
        miscompares++;
        $display("FAIL R10 (%s) busy_o actual=%0d expected=%0d t=%0t", cur_req, busy_o, m_busy, $time);
      end
      cyc++;
      tick_i <= (cyc % tick_div) == 0;
    end
  end

  task automatic hold(input logic v, input int n);
    din_i <= v;
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [1:0] m, input int per, input int div);
    rst <= 1'b1; din_i <= 1'b0;
    cur_req = "R1";
    repeat (2) @(negedge clk);
    mode_i <= m; period_i <= CNT_W'(per); tick_div = div;
    @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R3 R4: on-delay, ticks every cycle, then every third cycle
    restart(2'd0, 5, 1);
    cur_req = "R3"; hold(1, 10); cur_req = "R4"; hold(0, 4);
    cur_req = "R4"; hold(1, 4); hold(0, 3); hold(1, 5); hold(0, 2);
    restart(2'd0, 4, 3);
    cur_req = "R3"; hold(1, 20); cur_req = "R4"; hold(0, 3); hold(1, 8); hold(0, 5);
    // R2: code 3 acts as on-delay
    restart(2'd3, 3, 1);
    cur_req = "R2"; hold(1, 6); hold(0, 2); hold(1, 2); hold(0, 3);
    // R5 R6: off-delay
    restart(2'd1, 6, 1);
    cur_req = "R5"; hold(1, 3); cur_req = "R6"; hold(0, 10);
    hold(1, 2); hold(0, 3); hold(1, 1); hold(0, 9);
    restart(2'd1, 3, 3);
    cur_req = "R5"; hold(1, 2); cur_req = "R6"; hold(0, 12); hold(1, 1); hold(0, 4); hold(1, 2); hold(0, 12);
    // R7 R8: pulse
    restart(2'd2, 5, 1);
    cur_req = "R7"; hold(1, 1); hold(0, 8); hold(1, 12); hold(0, 2);
    cur_req = "R8"; hold(1, 2); hold(0, 1); hold(1, 1); hold(0, 1); hold(1, 6); hold(0, 3);
    restart(2'd2, 3, 3);
    cur_req = "R7"; hold(1, 15); hold(0, 2); cur_req = "R8"; hold(1, 2); hold(0, 2); hold(1, 2); hold(0, 12);
    // R9: zero period in every mode
    restart(2'd0, 0, 1);
    cur_req = "R9"; hold(1, 3); hold(0, 2); hold(1, 1); hold(0, 2);
    restart(2'd1, 0, 2);
    cur_req = "R9"; hold(1, 3); hold(0, 3); hold(1, 1); hold(0, 2);
    restart(2'd2, 0, 1);
    cur_req = "R9"; hold(1, 3); hold(0, 2); hold(1, 2); hold(0, 2);
    // R1: reset in the middle of a pulse
    restart(2'd2, 9, 1);
    cur_req = "R7"; hold(1, 3);
    rst <= 1'b1; cur_req = "R1"; hold(1, 3);
    rst <= 1'b0; hold(0, 12);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule